// File: doc/BRIEF.md
# Display Refresh and Switch Sampler

This block is a sweep sequencer for a board that drives four seven-segment digits through a cascade of 8-bit serial-in shift registers. The same serial path also reads eight switches through a parallel-load shift register that sits on the data-in line. A single request from the host logic starts one sweep, which does three things in order:

1. It pulses an active-low load strobe to freeze the switch levels in the input register.
2. It shifts all four digit bytes out over a mode-0 serial link (clock, data out, data in).
3. It keeps the byte clocked in during the first byte slot as the switch snapshot.

The host sees only a start/busy/done handshake, a packed digit word and the snapshot. The digit word is sampled when a sweep begins. The snapshot register changes only when the sweep completes. Segment decoding, debouncing and any output-latch strobes belong to other blocks.

Top module: `seg_sweep`

## Requirements
- R1: After reset `busy`, `done`, `sclk` and `mosi` are 0, `load_n` is 1 and `switches` is 0x00.
- R2: When a start is accepted, `load_n` goes low for LOAD_CYC (default 2, at least 2) system clocks. `sclk` stays low while `load_n` is low, and at least one system clock passes between the release of `load_n` and the first rising `sclk`.
- R3: A sweep issues exactly 32 rising `sclk` edges, one every DIV (default 4) system clocks. `sclk` is low whenever the block is not shifting.
- R4: Bits leave most significant first. The byte order is `digits[7:0]`, `digits[15:8]`, `digits[23:16]`, `digits[31:24]`. `mosi` never changes while `sclk` is high, so a downstream register clocking on the rising edge receives the stream intact.
- R5: `miso` is sampled on each rising `sclk`. The first 8 sampled bits, first bit as bit 7, form the snapshot. Bits sampled during later byte slots are not stored.
- R6: `switches` changes only in the cycle in which `done` is high.
- R7: `done` is high for exactly one system clock after the last falling `sclk`. `busy` is high from the cycle after start is accepted through that `done` cycle, and low in the next cycle.
- R8: `start` has no effect while `busy` is high. No second sweep follows a start raised during a sweep.
- R9: `digits` is captured when start is accepted. Changes to it during a sweep do not alter the shifted stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one sweep (accepted when idle) |
| digits | input | 32 | Four digit bytes, bits [7:0] sent first |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| switches | output | 8 | Switch snapshot of the last sweep |
| load_n | output | 1 | Active-low parallel-load strobe for the switch register |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the display chain |
| miso | input | 1 | Serial data from the switch register |

## Verification
The assertions assume that `miso` changes only away from rising `sclk` edges, as a real input register clocked on the falling edge would behave. They also assume that `start` is a synchronous level sampled on the system clock.

The bench models the switch register so that it loads while `load_n` is low and shifts on each falling `sclk`. It shifts ones in behind the switch byte, so a design that stored the wrong byte would show a different value. All stimulus is driven half a cycle away from the rising system clock.

// File: rtl/seg_sweep.sv
module seg_sweep #(
  parameter int DIV      = 4,
  parameter int LOAD_CYC = 2,
  parameter int GAP_CYC  = 1,
  parameter int NDIG     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [8*NDIG-1:0] digits,
  output logic              busy,
  output logic              done,
  output logic [7:0]        switches,
  output logic              load_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int NBITS = 8 * NDIG;
  localparam int HALF  = DIV / 2;
  localparam int BW    = $clog2(NBITS);
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CMAX  = (LOAD_CYC > GAP_CYC) ? LOAD_CYC : GAP_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_GAP, S_SHIFT, S_DONE} st_t;

  st_t              st;
  logic [NBITS-1:0] tx, tx_init;
  logic [BW-1:0]    bitc;
  logic [HW-1:0]    hcnt;
  logic [CW-1:0]    cnt;
  logic [6:0]       rx;
  logic [7:0]       snap;

  for (genvar i = 0; i < NDIG; i++) begin : g_order
    assign tx_init[NBITS-1-8*i -: 8] = digits[8*i +: 8];
  end

  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE);
  assign mosi = (st == S_SHIFT) & tx[NBITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tx       <= '0;
      bitc     <= '0;
      hcnt     <= '0;
      cnt      <= '0;
      rx       <= '0;
      snap     <= '0;
      switches <= '0;
      load_n   <= 1'b1;
      sclk     <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          tx     <= tx_init;
          cnt    <= '0;
          load_n <= 1'b0;
          st     <= S_LOAD;
        end
        S_LOAD: if (cnt == CW'(LOAD_CYC - 1)) begin
          load_n <= 1'b1;
          cnt    <= '0;
          st     <= S_GAP;
        end else cnt <= cnt + 1'b1;
        S_GAP: if (cnt == CW'(GAP_CYC - 1)) begin
          hcnt <= '0;
          bitc <= '0;
          st   <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (hcnt == HW'(HALF - 1)) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[5:0], miso};
            if (bitc == BW'(7)) snap <= {rx, miso};
          end else begin
            sclk <= 1'b0;
            if (bitc == BW'(NBITS - 1)) begin
              switches <= snap;
              st       <= S_DONE;
            end else begin
              bitc <= bitc + 1'b1;
              tx   <= tx << 1;
            end
          end
        end else hcnt <= hcnt + 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_clk_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> !sclk) else $error("sclk high during load strobe");
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk) else $error("sclk not idle low");
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)) else $error("mosi moved while sclk high");
  p_sw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(switches)) else $error("switches moved outside done");
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy) else $error("busy after done");
  p_stay_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy) else $error("sweep cut short");
endmodule

// File: tb/seg_sweep_tb.sv
module seg_sweep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] digits = '0;
  logic        busy, done, load_n, sclk, mosi, miso;
  logic [7:0]  switches;
  logic [7:0]  sw_in = '0, sw_sr = '0;
  int total = 0, bad = 0;

  assign miso = sw_sr[7];
  always #(CLK_PERIOD/2) clk = ~clk;

  seg_sweep u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .digits(digits),
    .busy(busy), .done(done), .switches(switches), .load_n(load_n),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sweep(input logic [31:0] d, input logic [7:0] sw, input int mode);
    logic [31:0] chain = '0;
    logic [31:0] exp_chain = {d[7:0], d[15:8], d[23:16], d[31:24]};
    logic psclk = 0, pmosi = 0;
    logic [7:0] psw = switches;
    int lowcnt = 0, hicnt = 0, gap = -1, rises = 0, last_rise = 0;
    int per_bad = 0, mosi_bad = 0, clk_in_load = 0, donecnt = 0, swchg = 0;
    digits = d; sw_in = sw;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      if (!load_n) begin lowcnt++; sw_sr = sw_in; if (sclk) clk_in_load++; end
      else if (lowcnt > 0 && rises == 0 && !sclk) hicnt++;
      if (sclk && !psclk) begin
        rises++;
        chain = {chain[30:0], mosi};
        if (rises == 1) gap = hicnt;
        else if (cyc - last_rise != DIV) per_bad++;
        last_rise = cyc;
      end
      if (!sclk && psclk) sw_sr = {sw_sr[6:0], 1'b1};
      if (sclk && psclk && mosi != pmosi) mosi_bad++;
      if (done) donecnt++;
      else if (switches != psw) swchg++;
      if (mode == 1 && cyc == 10) start = 1;
      if (mode == 1 && cyc == 11) start = 0;
      if (mode == 2 && cyc == 10) digits = ~d;
      if (mode == 3 && cyc == 10) sw_in = ~sw;
      psclk = sclk; pmosi = mosi; psw = switches;
      if (done) begin
        chk(switches == sw, "R5", "snapshot at done", switches, sw);
        break;
      end
      @(negedge clk);
    end
    chk(donecnt == 1, "R7", "done pulses", donecnt, 1);
    chk(lowcnt >= 2, "R2", "load strobe cycles", lowcnt, 2);
    chk(gap >= 1 && clk_in_load == 0, "R2", "load release gap", gap, 1);
    chk(rises == 32, "R3", "sclk rising edges", rises, 32);
    chk(per_bad == 0, "R3", "sclk period errors", per_bad, 0);
    chk(mosi_bad == 0, "R4", "mosi moves while sclk high", mosi_bad, 0);
    chk(chain == exp_chain, "R4", "display chain (R9 if mode 2)", chain, exp_chain);
    chk(swchg == 0, "R6", "switches moved before done", swchg, 0);
    @(negedge clk);
    chk(!busy && !done && !sclk, "R7", "idle after done", {busy, done, sclk}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !sclk && !mosi && load_n && switches == 0, "R1",
        "reset state", {busy, done, sclk, mosi, load_n, switches}, 14'h0100);
  endtask

  task automatic t_basic;
    sweep(32'h4F5B0636, 8'hA5, 0);
    sweep(32'h80000001, 8'h3C, 0);
    sweep(32'hFFFFFFFF, 8'h00, 0);
    sweep(32'h00000000, 8'h81, 0);
  endtask

  task automatic t_start_busy;
    sweep(32'h12345678, 8'h5A, 1);
    for (int i = 0; i < 8; i++) begin
      if (busy || !load_n) begin
        chk(0, "R8", "sweep after ignored start", {busy, load_n}, 2'b01);
        break;
      end
      @(negedge clk);
    end
    chk(!busy, "R8", "no second sweep", busy, 0);
  endtask

  task automatic t_digit_change;
    sweep(32'hC0FFEE11, 8'h69, 2);
  endtask

  task automatic t_switch_change;
    sweep(32'h0A0B0C0D, 8'h17, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_start_busy;
    t_digit_change;
    t_switch_change;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule